// File: doc/BRIEF.md
# Memory-Mapped Multiply/Divide Unit

This block is an arithmetic peripheral reached through a byte-wide synchronous register port. Software loads operands one byte at a time. A multiply runs in the same edge that completes the operand, with no command write. A 32-bit unsigned divide is started by a control write and runs in the background. Its result replaces the operands once a fixed latency has passed.

Operand register A holds two 16-bit halves. The moment all four bytes of A have been written since the last completion, the low half is multiplied by the high half. The 32-bit product lands in register B. In the accumulate modes, the product is also added into register C. A divide takes A as the dividend and B as the divisor. It puts the quotient back into A and the remainder into C. While it runs, the control register's bit 0 reads as a busy flag.

Top module: `muldiv_unit`

## Requirements
- R1: A synchronous active-high reset clears registers A, B, C, the control register, the lane mask and the busy state, so every address reads 0x00.
- R2: Byte addresses are little-endian: A at 0..3 (bytes 0–1 are the low half, bytes 2–3 the high half), B at 4..7, C at 8..11 and control at 12. A read returns the current byte combinationally, and addresses 13..15 read 0x00.
- R3: The multiply fires at the edge of the write that completes the set of four A lanes written since the last completion, and the lane mask then clears. Fewer lanes, or a repeated lane, do not fire it.
- R4: The mode is taken from control bits 7, 6 and 3 (value masked with 0xC8): 0x00 is unsigned multiply, 0x08 is signed multiply, 0x40 is unsigned multiply-accumulate and 0x48 is signed multiply-accumulate. Any other masked value completes the lane set without arithmetic.
- R5: The 32-bit product of A's low half times A's high half is written to B. Signed modes sign-extend each half from bit 15. The plain multiply modes leave C unchanged.
- R6: The accumulate modes also write C + product (modulo 2^32) to C in the same edge.
- R7: A control write with bits 7 and 0 both set starts a divide, and bit 0 then reads 1. A control write with bit 0 set and bit 7 clear leaves bit 0 reading 0. The other written bits read back as written.
- R8: After the start edge, bit 0 reads 1 through the 16th following edge. The results appear and bit 0 clears at the 17th following edge.
- R9: When the divide completes, A holds the unsigned quotient of A/B and C holds the remainder, both as they stood at the start edge. B keeps the divisor.
- R10: A zero divisor yields 0xFFFFFFFF for both the quotient and the remainder.
- R11: While busy, including the completion edge, bus writes to A, B, C and control are ignored, and the lane mask does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_addr | input | 4 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |

## Verification
Divide completion and a bus write can land on the same edge. The completion writes A and C, and the write could target the same register. The bench provokes this by timing a write to a C byte so that it meets the completion edge exactly. It judges the outcome by reading C back: C must hold the remainder and no trace of the written byte. A second write one cycle later must be accepted. Writes to B, A and control issued in the middle of the divide are checked the same way: B keeps the divisor and control still reads busy.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    localparam int BYTE_W  = 8;
    localparam int HALF_W  = 16;
    localparam int WORD_W  = 2 * HALF_W;
    localparam int LANES   = WORD_W / BYTE_W;
    localparam int LANE_W  = $clog2(LANES);
    localparam int ADDR_W  = LANE_W + 2;
    localparam int CTRL_W  = BYTE_W;

    // Register groups selected by the upper address bits
    typedef enum logic [1:0] {
        GRP_A    = 2'd0,
        GRP_B    = 2'd1,
        GRP_C    = 2'd2,
        GRP_CTRL = 2'd3
    } reg_grp_e;

    // Multiply configuration taken from the control byte
    typedef struct packed {
        logic valid;
        logic sign_ext;
        logic accumulate;
    } mul_cfg_t;

    function automatic mul_cfg_t decode_ctrl(input logic [CTRL_W-1:0] c);
        mul_cfg_t cfg;
        cfg = '0;
        case ({c[7], c[6], c[3]})
            3'b000: cfg = '{valid: 1'b1, sign_ext: 1'b0, accumulate: 1'b0};
            3'b001: cfg = '{valid: 1'b1, sign_ext: 1'b1, accumulate: 1'b0};
            3'b010: cfg = '{valid: 1'b1, sign_ext: 1'b0, accumulate: 1'b1};
            3'b011: cfg = '{valid: 1'b1, sign_ext: 1'b1, accumulate: 1'b1};
            default: cfg = '0;
        endcase
        return cfg;
    endfunction

    function automatic logic is_div_start(input logic [CTRL_W-1:0] c);
        return c[7] & c[0];
    endfunction

endpackage

// File: rtl/muldiv_mult.sv
module muldiv_mult
    import muldiv_pkg::*;
#(
    parameter int H_W = HALF_W
) (
    input  logic [H_W-1:0]   op_lo,
    input  logic [H_W-1:0]   op_hi,
    input  logic             sign_ext,
    input  logic             accumulate,
    input  logic [2*H_W-1:0] acc_in,
    output logic [2*H_W-1:0] product,
    output logic [2*H_W-1:0] acc_out
);
    localparam int P_W = 2 * H_W;

    logic [P_W-1:0] ext_lo;
    logic [P_W-1:0] ext_hi;

    // Extension to the full product width: the low P_W bits of the
    // product are then correct for both signed and unsigned operands.
    always_comb begin
        ext_lo  = {{H_W{sign_ext & op_lo[H_W-1]}}, op_lo};
        ext_hi  = {{H_W{sign_ext & op_hi[H_W-1]}}, op_hi};
        product = ext_lo * ext_hi;
        acc_out = accumulate ? (acc_in + product) : acc_in;
    end

endmodule

// File: rtl/muldiv_divider.sv
module muldiv_divider #(
    parameter int W      = 32,
    parameter int CYCLES = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder
);
    localparam int STEPS = W / CYCLES;
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [W-1:0]     quo_q;
    logic [W-1:0]     rem_q;
    logic [W-1:0]     dvs_q;
    logic             zero_q;
    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;

    logic [W-1:0]     quo_n;
    logic [W-1:0]     rem_n;

    // STEPS restoring-division steps per cycle
    always_comb begin
        logic [W:0]   r;
        logic [W-1:0] q;
        r = {1'b0, rem_q};
        q = quo_q;
        for (int i = 0; i < STEPS; i++) begin
            r = {r[W-1:0], q[W-1]};
            q = {q[W-2:0], 1'b0};
            if (r >= {1'b0, dvs_q}) begin
                r    = r - {1'b0, dvs_q};
                q[0] = 1'b1;
            end
        end
        quo_n = q;
        rem_n = r[W-1:0];
    end

    assign done = busy_q && (cnt_q == CNT_W'(CYCLES));
    assign busy = busy_q;
    assign quotient  = zero_q ? '1 : quo_q;
    assign remainder = zero_q ? '1 : rem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            quo_q  <= '0;
            rem_q  <= '0;
            dvs_q  <= '0;
            zero_q <= 1'b0;
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start && !busy_q) begin
            quo_q  <= dividend;
            rem_q  <= '0;
            dvs_q  <= divisor;
            zero_q <= (divisor == '0);
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (busy_q) begin
            if (done) begin
                busy_q <= 1'b0;
            end else begin
                quo_q <= quo_n;
                rem_q <= rem_n;
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int DIV_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata
);
    logic [WORD_W-1:0] a_q, b_q, c_q;
    logic [WORD_W-1:0] a_bus, b_bus, c_bus;
    logic [WORD_W-1:0] prod, c_mac, quotient, remainder;
    logic [CTRL_W-1:1] ctrl_q;
    logic [LANES-1:0]  lane_mask_q, lane_sel, lane_hit, mask_next;
    logic              div_busy, div_done, div_start;
    logic              wr_ok, wr_a, wr_b, wr_c, wr_ctrl, a_full;
    logic              mul_fire, mul_acc;
    mul_cfg_t          mul_cfg;
    reg_grp_e          grp;
    logic [LANE_W-1:0] lane;

    assign grp  = reg_grp_e'(bus_addr[ADDR_W-1:LANE_W]);
    assign lane = bus_addr[LANE_W-1:0];

    // Bus writes are dropped whenever a divide owns the registers
    assign wr_ok   = bus_wr && !div_busy;
    assign wr_a    = wr_ok && (grp == GRP_A);
    assign wr_b    = wr_ok && (grp == GRP_B);
    assign wr_c    = wr_ok && (grp == GRP_C);
    assign wr_ctrl = wr_ok && (grp == GRP_CTRL) && (lane == '0);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_sel[k] = (lane == LANE_W'(k));
        assign a_bus[k*BYTE_W +: BYTE_W] = (wr_a && lane_sel[k]) ? bus_wdata : a_q[k*BYTE_W +: BYTE_W];
        assign b_bus[k*BYTE_W +: BYTE_W] = (wr_b && lane_sel[k]) ? bus_wdata : b_q[k*BYTE_W +: BYTE_W];
        assign c_bus[k*BYTE_W +: BYTE_W] = (wr_c && lane_sel[k]) ? bus_wdata : c_q[k*BYTE_W +: BYTE_W];
    end

    assign lane_hit  = wr_a ? lane_sel : '0;
    assign mask_next = lane_mask_q | lane_hit;
    assign a_full    = wr_a && (&mask_next);
    assign mul_cfg   = decode_ctrl({ctrl_q, 1'b0});
    assign mul_fire  = a_full && mul_cfg.valid;
    assign mul_acc   = mul_cfg.accumulate;
    assign div_start = wr_ctrl && is_div_start(bus_wdata);

    muldiv_mult #(.H_W(HALF_W)) i_mult (
        .op_lo      (a_bus[HALF_W-1:0]),
        .op_hi      (a_bus[WORD_W-1:HALF_W]),
        .sign_ext   (mul_cfg.sign_ext),
        .accumulate (mul_cfg.accumulate),
        .acc_in     (c_q),
        .product    (prod),
        .acc_out    (c_mac)
    );

    muldiv_divider #(.W(WORD_W), .CYCLES(DIV_CYCLES)) i_div (
        .clk       (clk),
        .rst       (rst),
        .start     (div_start),
        .dividend  (a_q),
        .divisor   (b_q),
        .busy      (div_busy),
        .done      (div_done),
        .quotient  (quotient),
        .remainder (remainder)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q         <= '0;
            b_q         <= '0;
            c_q         <= '0;
            ctrl_q      <= '0;
            lane_mask_q <= '0;
        end else begin
            a_q <= div_done ? quotient : a_bus;
            b_q <= mul_fire ? prod : b_bus;
            if (div_done) begin
                c_q <= remainder;
            end else if (mul_fire) begin
                c_q <= c_mac;
            end else begin
                c_q <= c_bus;
            end
            if (wr_a) begin
                lane_mask_q <= a_full ? '0 : mask_next;
            end
            if (wr_ctrl) begin
                ctrl_q <= bus_wdata[CTRL_W-1:1];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (grp)
            GRP_A:    bus_rdata = a_q[{lane, 3'b000} +: BYTE_W];
            GRP_B:    bus_rdata = b_q[{lane, 3'b000} +: BYTE_W];
            GRP_C:    bus_rdata = c_q[{lane, 3'b000} +: BYTE_W];
            GRP_CTRL: bus_rdata = (lane == '0) ? {ctrl_q, div_busy} : '0;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/muldiv_checker.sv
module muldiv_checker
    import muldiv_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BYTE_W-1:0] bus_wdata,
    input logic              div_busy,
    input logic              div_done,
    input logic [WORD_W-1:0] b_q,
    input logic [WORD_W-1:0] c_q,
    input logic [LANES-1:0]  lane_mask_q,
    input logic              mul_fire,
    input logic              mul_acc
);
    // R7
    div_start_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(12) && bus_wdata[7] && bus_wdata[0] && !div_busy) |=> div_busy);

    // R8
    div_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (div_busy && !div_done) |=> div_busy);

    // R8
    div_release_chk: assert property (@(posedge clk) disable iff (rst)
        (div_busy && div_done) |=> !div_busy);

    // R11
    busy_b_chk: assert property (@(posedge clk) disable iff (rst)
        div_busy |=> $stable(b_q));

    // R11
    busy_mask_chk: assert property (@(posedge clk) disable iff (rst)
        div_busy |=> $stable(lane_mask_q));

    // R5
    plain_c_chk: assert property (@(posedge clk) disable iff (rst)
        (mul_fire && !mul_acc) |=> $stable(c_q));

    // R3
    mask_clear_chk: assert property (@(posedge clk) disable iff (rst)
        mul_fire |=> (lane_mask_q == '0));

endmodule

bind muldiv_unit muldiv_checker i_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .div_busy    (div_busy),
    .div_done    (div_done),
    .b_q         (b_q),
    .c_q         (c_q),
    .lane_mask_q (lane_mask_q),
    .mul_fire    (mul_fire),
    .mul_acc     (mul_acc)
);

// File: tb/test_muldiv_unit.sv
`timescale 1ns/100ps
module test_muldiv_unit;

    localparam logic [3:0] A_AD = 4'd0;
    localparam logic [3:0] B_AD = 4'd4;
    localparam logic [3:0] C_AD = 4'd8;
    localparam logic [3:0] K_AD = 4'd12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    muldiv_unit i_muldiv_unit (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    always #2.5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr_byte(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wr_word(input logic [3:0] base, input logic [31:0] v);
        for (int i = 0; i < 4; i++) wr_byte(base + 4'(i), v[i*8 +: 8]);
    endtask

    task automatic peek(input logic [3:0] a, output logic [7:0] v);
        bus_addr = a;
        #0.5;
        v = bus_rdata;
    endtask

    task automatic rd_word(input logic [3:0] base, output logic [31:0] v);
        logic [7:0] b;
        for (int i = 0; i < 4; i++) begin
            peek(base + 4'(i), b);
            v[i*8 +: 8] = b;
        end
    endtask

    task automatic t_reset;
        logic [7:0] v;
        for (int i = 0; i < 16; i++) begin
            peek(4'(i), v);
            check("R1 reset read", {24'd0, v}, 32'd0);
        end
        peek(4'd13, v);
        check("R2 unmapped read", {24'd0, v}, 32'd0);
    endtask

    task automatic t_umul;
        logic [31:0] v;
        wr_word(A_AD, 32'hFFFF_FFFF);
        rd_word(B_AD, v); check("R5 unsigned product", v, 32'hFFFE_0001);
        rd_word(C_AD, v); check("R5 C kept on plain multiply", v, 32'd0);
        rd_word(A_AD, v); check("R2 A readback", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_smul;
        logic [31:0] v;
        logic [7:0]  k;
        wr_byte(K_AD, 8'h08);
        peek(K_AD, k); check("R7 ctrl readback", {24'd0, k}, 32'h08);
        wr_word(A_AD, 32'h0003_FFFF);
        rd_word(B_AD, v); check("R4 signed product -1*3", v, 32'hFFFF_FFFD);
        wr_word(A_AD, 32'hFFFF_FFFF);
        rd_word(B_AD, v); check("R4 signed product -1*-1", v, 32'h0000_0001);
    endtask

    task automatic t_umac;
        logic [31:0] v;
        wr_byte(K_AD, 8'h40);
        wr_word(C_AD, 32'h0000_0010);
        wr_word(A_AD, 32'h0010_1000);
        rd_word(B_AD, v); check("R6 umac product", v, 32'h0001_0000);
        rd_word(C_AD, v); check("R6 umac accumulate", v, 32'h0001_0010);
        wr_word(A_AD, 32'h0002_0003);
        rd_word(C_AD, v); check("R6 umac second accumulate", v, 32'h0001_0016);
    endtask

    task automatic t_smac;
        logic [31:0] v;
        wr_byte(K_AD, 8'h48);
        wr_word(C_AD, 32'h0000_0005);
        wr_word(A_AD, 32'h0003_FFFE);
        rd_word(B_AD, v); check("R6 smac product", v, 32'hFFFF_FFFA);
        rd_word(C_AD, v); check("R6 smac accumulate", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_partial;
        logic [31:0] v;
        wr_byte(K_AD, 8'h00);
        wr_word(B_AD, 32'h1234_5678);
        wr_byte(A_AD + 4'd0, 8'h03);
        wr_byte(A_AD + 4'd1, 8'h00);
        wr_byte(A_AD + 4'd2, 8'h05);
        wr_byte(A_AD + 4'd0, 8'h04);
        rd_word(B_AD, v); check("R3 no fire on three lanes", v, 32'h1234_5678);
        wr_byte(A_AD + 4'd3, 8'h00);
        rd_word(B_AD, v); check("R3 fire on fourth lane", v, 32'd20);
        wr_byte(A_AD + 4'd3, 8'h01);
        rd_word(B_AD, v); check("R3 mask cleared after fire", v, 32'd20);
    endtask

    task automatic t_divide;
        logic [31:0] v;
        logic [7:0]  k;
        wr_byte(K_AD, 8'h80);
        wr_word(A_AD, 32'd1000003);
        rd_word(B_AD, v); check("R4 no arithmetic in mode 0x80", v, 32'd20);
        wr_word(B_AD, 32'd7);
        wr_byte(K_AD, 8'h81);
        peek(K_AD, k); check("R7 busy after start", {24'd0, k}, 32'h81);
        repeat (16) @(negedge clk);
        peek(K_AD, k); check("R8 busy at 16th edge", {24'd0, k}, 32'h81);
        @(negedge clk);
        peek(K_AD, k); check("R8 clear at 17th edge", {24'd0, k}, 32'h80);
        rd_word(A_AD, v); check("R9 quotient", v, 32'd142857);
        rd_word(C_AD, v); check("R9 remainder", v, 32'd4);
        rd_word(B_AD, v); check("R9 divisor kept", v, 32'd7);
    endtask

    task automatic t_divzero;
        logic [31:0] v;
        wr_word(A_AD, 32'd12345);
        wr_word(B_AD, 32'd0);
        wr_byte(K_AD, 8'h81);
        repeat (17) @(negedge clk);
        rd_word(A_AD, v); check("R10 zero divisor quotient", v, 32'hFFFF_FFFF);
        rd_word(C_AD, v); check("R10 zero divisor remainder", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_busy_ignore;
        logic [31:0] v;
        logic [7:0]  k;
        wr_word(A_AD, 32'hFFFF_FFFF);
        wr_word(B_AD, 32'h0001_0000);
        wr_byte(K_AD, 8'h81);
        wr_byte(B_AD, 8'h12);
        wr_byte(A_AD, 8'h00);
        wr_byte(K_AD, 8'h00);
        peek(K_AD, k); check("R11 ctrl write ignored while busy", {24'd0, k}, 32'h81);
        repeat (9) @(negedge clk);
        wr_byte(C_AD, 8'hAA);
        rd_word(C_AD, v); check("R11 write on completion edge dropped", v, 32'h0000_FFFF);
        rd_word(A_AD, v); check("R9 quotient large", v, 32'h0000_FFFF);
        rd_word(B_AD, v); check("R11 B write ignored while busy", v, 32'h0001_0000);
        peek(K_AD, k); check("R8 idle after completion", {24'd0, k}, 32'h80);
        wr_byte(C_AD + 4'd1, 8'h55);
        rd_word(C_AD, v); check("R11 write accepted after busy", v, 32'h0000_55FF);
    endtask

    task automatic t_start_needs_bit7;
        logic [7:0] k;
        wr_byte(K_AD, 8'h01);
        peek(K_AD, k); check("R7 bit0 without bit7 no start", {24'd0, k}, 32'h00);
        @(negedge clk);
        peek(K_AD, k); check("R7 still idle", {24'd0, k}, 32'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            failures++;
            $display("FAIL R8 watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_umul();
        t_smul();
        t_umac();
        t_smac();
        t_partial();
        t_divide();
        t_divzero();
        t_busy_ignore();
        t_start_needs_bit7();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule